// File: doc/BRIEF.md
# Partitioned SIMD Lane Comparator

This block compares two 64-bit operands that software may treat either as one wide number or as a set of narrower packed values. The datapath is cut into eight 8-bit minimal lanes, and a 7-bit boundary vector decides at run time which neighbouring lanes stay joined. A run of joined lanes forms one partition. Each partition is compared as a single unsigned number.

An operation select chooses one of six relations: equal, not equal, greater, greater or equal, less, and less or equal. The block returns one predicate bit per minimal lane. Every lane bit inside a partition carries the same value, which is that partition's one-bit result, so downstream masking logic can use the vector directly as a lane-enable mask. The block is purely combinational and has no clock or reset.

Top module: `simd_part_cmp`

## Requirements
- R1: Minimal lane i covers operand bits [8*i+7 : 8*i]. Boundary bit `cut_i[i]` lies between lane i and lane i+1. A value of 1 separates the two lanes and a value of 0 joins them into one partition.
- R2: Op code 0 sets a partition's result to 1 when its two operand slices are equal. Op code 1 sets it to 1 when they differ.
- R3: Every predicate bit of a partition carries the same value, so when `cut_i[i]` is 0, `pred_o[i]` equals `pred_o[i+1]`.
- R4: Op code 2 gives the unsigned greater-than of operand A over operand B on the partition slice. Op code 3 gives greater-or-equal.
- R5: Op code 4 gives the unsigned less-than on the partition slice. Op code 5 gives less-or-equal.
- R6: A merged partition is compared as one number of 8*w bits. The most significant differing lane decides the order, and lower lanes matter only when every higher lane of the partition is equal.
- R7: Op codes 6 and 7 drive every predicate bit to 0.
- R8: The output is a pure function of the present inputs. With all inputs at zero and op code 0, `pred_o` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| cut_i | input | 7 | Lane boundary bits; 1 separates, 0 joins |
| op_i | input | 3 | Relation select, codes 0 to 7 |
| pred_o | output | 8 | One predicate bit per minimal lane |

## Verification
The case that is hardest to reach is a wide partition in which the upper lanes are equal and only a low lane differs. With independent random operands, a high lane almost always decides the result. The stimulus therefore builds B from A and then changes at most one randomly chosen byte, or none. This sends the comparison deep into every partition shape, and it is repeated for all 128 boundary patterns under every op code. Directed cases add a merged partition whose top byte and bottom byte point in opposite directions, so that the order of significance is exposed.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_GT = 3'd2,
        REL_GE = 3'd3,
        REL_LT = 3'd4,
        REL_LE = 3'd5
    } rel_op_e;

    // per-lane relation flags
    typedef struct packed {
        logic same;
        logic above;
    } lane_rel_t;

endpackage

// File: rtl/spc_lane_rel.sv
module spc_lane_rel
    import spc_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] x_i,
    input  logic [LANE_W-1:0] y_i,
    output lane_rel_t         rel_o
);

    always_comb begin
        rel_o.same  = (x_i == y_i);
        rel_o.above = (x_i > y_i);
    end

endmodule

// File: rtl/spc_part_scan.sv
module spc_part_scan #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] same_i,
    input  logic [LANES-1:0] above_i,
    input  logic [LANES-2:0] cut_i,
    output logic [LANES-1:0] same_o,
    output logic [LANES-1:0] above_o
);

    logic [LANES-1:0] acc_same_d;
    logic [LANES-1:0] acc_above_d;

    // Downward scan: fold each partition from its top lane toward its bottom lane.
    always_comb begin
        acc_same_d  = '0;
        acc_above_d = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (i == LANES - 1 || cut_i[i]) begin
                acc_same_d[i]  = same_i[i];
                acc_above_d[i] = above_i[i];
            end else begin
                acc_same_d[i]  = same_i[i] & acc_same_d[i+1];
                acc_above_d[i] = acc_above_d[i+1] | (acc_same_d[i+1] & above_i[i]);
            end
        end
    end

    // Upward broadcast: the bottom lane of each partition holds the full result.
    always_comb begin
        same_o  = '0;
        above_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i == 0 || cut_i[i-1]) begin
                same_o[i]  = acc_same_d[i];
                above_o[i] = acc_above_d[i];
            end else begin
                same_o[i]  = same_o[i-1];
                above_o[i] = above_o[i-1];
            end
        end
    end

    // R6: a partition can never be both equal and ordered above
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            a_r6_same_above_excl: assert (!(same_o[i] && above_o[i]))
                else $error("lane %0d flagged both equal and above", i);
        end
    end

endmodule

// File: rtl/spc_pred_sel.sv
module spc_pred_sel
    import spc_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic [2:0]       op_i,
    input  logic [LANES-1:0] same_i,
    input  logic [LANES-1:0] above_i,
    output logic [LANES-1:0] pred_o
);

    always_comb begin
        unique case (op_i)
            REL_EQ:  pred_o = same_i;
            REL_NE:  pred_o = ~same_i;
            REL_GT:  pred_o = above_i;
            REL_GE:  pred_o = above_i | same_i;
            REL_LT:  pred_o = ~(above_i | same_i);
            REL_LE:  pred_o = ~above_i;
            default: pred_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_part_cmp.sv
module simd_part_cmp
    import spc_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 8,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [LANES-2:0]  cut_i,
    input  logic [2:0]        op_i,
    output logic [LANES-1:0]  pred_o
);

    logic [LANES-1:0] lane_same;
    logic [LANES-1:0] lane_above;
    logic [LANES-1:0] part_same;
    logic [LANES-1:0] part_above;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_rel_t rel;
        spc_lane_rel #(.LANE_W(LANE_W)) u_rel (
            .x_i   (a_i[g*LANE_W +: LANE_W]),
            .y_i   (b_i[g*LANE_W +: LANE_W]),
            .rel_o (rel)
        );
        assign lane_same[g]  = rel.same;
        assign lane_above[g] = rel.above;
    end

    spc_part_scan #(.LANES(LANES)) u_scan (
        .same_i  (lane_same),
        .above_i (lane_above),
        .cut_i   (cut_i),
        .same_o  (part_same),
        .above_o (part_above)
    );

    spc_pred_sel #(.LANES(LANES)) u_sel (
        .op_i    (op_i),
        .same_i  (part_same),
        .above_i (part_above),
        .pred_o  (pred_o)
    );

    // Port-level checks against independent full-width comparisons
    always_comb begin
        for (int i = 0; i < LANES - 1; i++) begin
            a_r3_joined_lanes_match: assert (cut_i[i] || pred_o[i] == pred_o[i+1])
                else $error("joined lanes %0d/%0d disagree", i, i + 1);
        end
        if (cut_i == '0 && op_i == REL_EQ) begin
            a_r2_whole_eq: assert (pred_o == ((a_i == b_i) ? '1 : '0))
                else $error("whole-width equality mismatch");
        end
        if (cut_i == '0 && op_i == REL_GT) begin
            a_r6_whole_gt: assert (pred_o[0] == (a_i > b_i))
                else $error("whole-width greater-than mismatch");
        end
        if (op_i[2:1] == 2'b11) begin
            a_r7_unused_zero: assert (pred_o == '0)
                else $error("unused op code drove a predicate");
        end
    end

endmodule

// File: tb/tb_simd_part_cmp.sv
`timescale 1ns/1ps
module tb_simd_part_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a, b;
    logic [6:0]  cut;
    logic [2:0]  op;
    logic [7:0]  pred;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    simd_part_cmp dut (
        .a_i    (a),
        .b_i    (b),
        .cut_i  (cut),
        .op_i   (op),
        .pred_o (pred)
    );

    // behavioural reference: locate each lane's partition, slice, compare
    function automatic logic [7:0] ref_pred(input logic [63:0] x, input logic [63:0] y,
                                            input logic [6:0] c, input logic [2:0] o);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            int lo, hi, w;
            logic [63:0] m, xs, ys;
            logic bit_r;
            lo = i;
            while (lo > 0 && !c[lo-1]) lo--;
            hi = i;
            while (hi < 7 && !c[hi]) hi++;
            w = 8 * (hi - lo + 1);
            m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            xs = (x >> (8 * lo)) & m;
            ys = (y >> (8 * lo)) & m;
            case (o)
                3'd0: bit_r = (xs == ys);
                3'd1: bit_r = (xs != ys);
                3'd2: bit_r = (xs > ys);
                3'd3: bit_r = (xs >= ys);
                3'd4: bit_r = (xs < ys);
                3'd5: bit_r = (xs <= ys);
                default: bit_r = 1'b0;
            endcase
            r[i] = bit_r;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h cut=%b op=%0d got=%b exp=%b",
                     req, a, b, cut, op, got, exp);
        end
    endtask

    // drive on the falling edge, compare one ns after the rising edge
    task automatic apply(input logic [63:0] x, input logic [63:0] y,
                         input logic [6:0] c, input logic [2:0] o, input string req);
        @(negedge clk);
        a = x; b = y; cut = c; op = o;
        @(posedge clk);
        #1;
        check(req, pred, ref_pred(x, y, c, o));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8: watchdog expired got=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        a = '0; b = '0; cut = '0; op = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R8", pred, 8'hFF);   // zero inputs, equality, no state needed
        rst_n = 1'b1;

        // R1: all lanes separate, per-byte results
        apply(64'h00FF_1080_7F01_0203, 64'h00FE_1080_8001_0302, 7'h7F, 3'd2, "R1");
        check("R1", pred, 8'b0100_0001);
        // R6: top byte above, bottom byte below, one merged partition
        apply(64'h0200_0000_0000_0000, 64'h0100_0000_0000_00FF, 7'h00, 3'd2, "R6");
        check("R6", pred, 8'hFF);
        // R6: higher bytes equal, lowest byte decides
        apply(64'hAAAA_AAAA_AAAA_AA01, 64'hAAAA_AAAA_AAAA_AA02, 7'h00, 3'd4, "R6");
        check("R6", pred, 8'hFF);
        // R3: two 32-bit halves with opposite order
        apply(64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0000, 7'b000_1000, 3'd5, "R3");
        check("R3", pred, 8'b1111_0000);
        // R7: unused codes with equal operands
        apply(64'h1234, 64'h1234, 7'h00, 3'd6, "R7");
        apply(64'h1234, 64'h1234, 7'h55, 3'd7, "R7");
        check("R7", pred, 8'h00);

        // sweep every boundary pattern under every op code
        for (int o = 0; o < 8; o++) begin
            for (int c = 0; c < 128; c++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [63:0] x, y;
                    int byte_sel;
                    x = {$urandom, $urandom};
                    y = x;
                    if (k == 0) y = {$urandom, $urandom};
                    if (k == 2) begin
                        byte_sel = $urandom_range(7);
                        y[byte_sel*8 +: 8] = 8'($urandom);
                    end
                    apply(x, y, 7'(c), 3'(o), tag_of(3'(o)));
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule